// File: doc/BRIEF.md
# Transmit Mailbox Priority Selector

This block decides which of a CAN controller's transmit mailboxes goes out next. Mailboxes are numbered 0 to 31. Mailbox 0 never transmits, so 31 candidates are considered. The block takes three inputs: a vector of pending transmit requests, the arbitration fields of every mailbox, and an ordering mode. From these it reports the index of the winning mailbox and a flag that says whether any mailbox won.

There are two orderings:
- **Identifier order** (the default after reset). The winner is the mailbox whose frame would win bus arbitration if every pending frame started on the bus at the same instant.
- **Mailbox-number order.** The highest-numbered pending mailbox wins, so mailbox 31 is first and mailbox 1 is last.

The ordering bit is held in a register. It accepts a write only while the controller reports that it is stopped, meaning it is in reset or halt. The winner is found by combinational logic. It is captured into the output registers when an evaluate strobe is given.

Top module: `mbx_tx_sel`

## Requirements
- R1: After synchronous reset, `order_o` is 0 (identifier order), `win_valid_o` is 0 and `win_idx_o` is 0.
- R2: A pulse on `order_wr_i` loads `order_val_i` into the ordering register only when `ctrl_stopped_i` is 1. When `ctrl_stopped_i` is 0, the write is ignored and `order_o` keeps its value.
- R3: Mailbox 0 is never a candidate. Bit 0 of `tx_pend_i` has no effect on the result, and a valid result never reports index 0.
- R4: When `order_o` is 1, the winner is the highest-numbered mailbox whose `tx_pend_i` bit is set. Identifiers are not considered in this mode.
- R5: Each mailbox has a 31-bit slot in `mb_frames_i`. Slot k occupies bits [k*31+30 : k*31], and its fields are:
  - bit 30: frame format (1 = extended);
  - bit 29: remote request;
  - bits 28:18: base identifier;
  - bits 17:0: identifier extension.
  When `order_o` is 0, the pending mailbox with the numerically lowest base identifier wins.
- R6: In identifier order, the arbitration bits are compared in bus order, and a 0 (dominant) bit wins. A standard frame has its remote-request bit and then a dominant format bit after the base identifier. An extended frame has a recessive substitute bit and a recessive format bit, then the 18-bit extension, then its remote-request bit. As a result:
  - a standard frame, data or remote, beats an extended frame with the same base identifier;
  - among extended frames with the same base identifier, the lower extension wins.
- R7: In identifier order, a data frame beats a remote frame with the same identifier and format.
- R8: In identifier order, when two pending mailboxes have identical arbitration fields, the higher mailbox number wins.
- R9: When an evaluation finds no pending mailbox among 1 to 31, `win_valid_o` is 0 and `win_idx_o` is 0.
- R10: The outputs change only in the cycle after `eval_i` is high. Without `eval_i`, they hold their value even if the requests, frames or ordering change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ctrl_stopped_i | input | 1 | Controller is in reset or halt; enables ordering writes |
| order_wr_i | input | 1 | Write strobe for the ordering bit |
| order_val_i | input | 1 | New ordering: 0 identifier, 1 mailbox number |
| order_o | output | 1 | Current ordering bit |
| eval_i | input | 1 | Evaluate strobe; the result is registered on this edge |
| tx_pend_i | input | 32 | Pending transmit request per mailbox |
| mb_frames_i | input | 992 | Arbitration fields, one 31-bit slot per mailbox |
| win_valid_o | output | 1 | A pending mailbox was found |
| win_idx_o | output | 5 | Index of the winning mailbox |

## Verification
The bench gives the block several request patterns, and each one is built to tell a correct rule from a wrong one.
- **Mailbox-number order.** Scattered request sets show whether the highest pending number wins rather than the lowest or first one found. A set containing only mailbox 0 shows that slot is excluded.
- **Base identifiers.** In identifier order, base identifiers are spread so that the lowest one sits on a middle mailbox. A number-based pick would then choose a different mailbox.
- **Arbitration bit order.** Standard/extended pairs, data/remote pairs and pairs differing only in the extension each isolate one position in the bus-order comparison.
- **Tie-break.** Identical frames in two mailboxes check which one wins a tie.
- **Hold behaviour.** Changing the inputs without the strobe checks that the registered result holds.

// File: rtl/mbx_sel_pkg.sv
package mbx_sel_pkg;

    localparam int BASE_W = 11;
    localparam int EXT_W  = 18;
    localparam int SLOT_W = BASE_W + EXT_W + 2;
    localparam int KEY_W  = BASE_W + EXT_W + 3;

    typedef struct packed {
        logic              ide;
        logic              rtr;
        logic [BASE_W-1:0] base;
        logic [EXT_W-1:0]  ext;
    } mb_frame_t;

    typedef enum logic {
        ORD_BY_ID  = 1'b0,
        ORD_BY_NUM = 1'b1
    } tx_order_e;

    // Arbitration bits as they appear on the wire; smaller value wins.
    function automatic logic [KEY_W-1:0] arb_key(input mb_frame_t f);
        if (f.ide)
            return {f.base, 1'b1, 1'b1, f.ext, f.rtr};
        else
            return {f.base, f.rtr, 1'b0, {EXT_W{1'b0}}, 1'b0};
    endfunction

endpackage

// File: rtl/mbx_order_reg.sv
module mbx_order_reg
    import mbx_sel_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      wr_i,
    input  logic      val_i,
    input  logic      stopped_i,
    output tx_order_e order_o
);

    tx_order_e order_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            order_q <= ORD_BY_ID;
        else if (wr_i && stopped_i)
            order_q <= tx_order_e'(val_i);
    end

    assign order_o = order_q;

    assert_order_locked_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && !stopped_i) |=> $stable(order_q));

    assert_order_loads_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && stopped_i) |=> (order_q == tx_order_e'($past(val_i))));

endmodule

// File: rtl/mbx_key_gen.sv
module mbx_key_gen
    import mbx_sel_pkg::*;
#(
    parameter int NUM_MB = 32
) (
    input  logic [NUM_MB*SLOT_W-1:0]     frames_i,
    output logic [NUM_MB-1:0][KEY_W-1:0] keys_o
);

    for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
        mb_frame_t fr;
        assign fr        = mb_frame_t'(frames_i[g*SLOT_W +: SLOT_W]);
        assign keys_o[g] = arb_key(fr);
    end

endmodule

// File: rtl/mbx_pick.sv
module mbx_pick
    import mbx_sel_pkg::*;
#(
    parameter int NUM_MB = 32,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic [NUM_MB-1:0]            pend_i,
    input  logic [NUM_MB-1:0][KEY_W-1:0] keys_i,
    input  tx_order_e                    order_i,
    output logic                         found_o,
    output logic [IDX_W-1:0]             idx_o
);

    logic [NUM_MB-1:0] cand;
    logic [KEY_W-1:0]  best;

    // Slot 0 is a receive-only mailbox and never competes.
    assign cand = pend_i & ~NUM_MB'(1);

    // Ascending scan: a later (higher) mailbox replaces on equal key.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '1;
        for (int i = 0; i < NUM_MB; i++) begin
            if (cand[i]) begin
                if (order_i == ORD_BY_NUM) begin
                    found_o = 1'b1;
                    idx_o   = IDX_W'(i);
                end else if (!found_o || keys_i[i] <= best) begin
                    found_o = 1'b1;
                    idx_o   = IDX_W'(i);
                    best    = keys_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/mbx_tx_sel.sv
module mbx_tx_sel
    import mbx_sel_pkg::*;
#(
    parameter int NUM_MB = 32,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     ctrl_stopped_i,
    input  logic                     order_wr_i,
    input  logic                     order_val_i,
    output logic                     order_o,
    input  logic                     eval_i,
    input  logic [NUM_MB-1:0]        tx_pend_i,
    input  logic [NUM_MB*SLOT_W-1:0] mb_frames_i,
    output logic                     win_valid_o,
    output logic [IDX_W-1:0]         win_idx_o
);

    tx_order_e                    order;
    logic [NUM_MB-1:0][KEY_W-1:0] keys;
    logic                         found;
    logic [IDX_W-1:0]             pick_idx;
    logic                         valid_q;
    logic [IDX_W-1:0]             idx_q;

    mbx_order_reg u_order (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_i      (order_wr_i),
        .val_i     (order_val_i),
        .stopped_i (ctrl_stopped_i),
        .order_o   (order)
    );

    mbx_key_gen #(.NUM_MB(NUM_MB)) u_keys (
        .frames_i (mb_frames_i),
        .keys_o   (keys)
    );

    mbx_pick #(.NUM_MB(NUM_MB)) u_pick (
        .pend_i  (tx_pend_i),
        .keys_i  (keys),
        .order_i (order),
        .found_o (found),
        .idx_o   (pick_idx)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else if (eval_i) begin
            valid_q <= found;
            idx_q   <= found ? pick_idx : '0;
        end
    end

    assign order_o     = order;
    assign win_valid_o = valid_q;
    assign win_idx_o   = idx_q;

    assert_hold_no_eval_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !eval_i |=> ($stable(valid_q) && $stable(idx_q)));

    assert_empty_result_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (eval_i && tx_pend_i[NUM_MB-1:1] == '0) |=> (!valid_q && idx_q == '0));

    assert_slot0_excluded_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_q |-> (idx_q != '0));

    assert_valid_tracks_pend_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        eval_i |=> (valid_q == $past(|tx_pend_i[NUM_MB-1:1])));

    assert_top_number_wins_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (eval_i && order == ORD_BY_NUM && tx_pend_i[NUM_MB-1]) |=> (idx_q == IDX_W'(NUM_MB-1)));

endmodule

// File: tb/mbx_tx_sel_tb.sv
module mbx_tx_sel_tb_top;
    import mbx_sel_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NMB        = 32;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   stopped;
    logic                   ord_wr;
    logic                   ord_val;
    logic                   ord_out;
    logic                   eval;
    logic [NMB-1:0]         pend;
    logic [NMB*SLOT_W-1:0]  frames_flat;
    logic                   valid_o;
    logic [4:0]             idx_o;
    logic [SLOT_W-1:0]      fr [NMB];

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NMB; i++)
            frames_flat[i*SLOT_W +: SLOT_W] = fr[i];
    end

    mbx_tx_sel dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .ctrl_stopped_i (stopped),
        .order_wr_i     (ord_wr),
        .order_val_i    (ord_val),
        .order_o        (ord_out),
        .eval_i         (eval),
        .tx_pend_i      (pend),
        .mb_frames_i    (frames_flat),
        .win_valid_o    (valid_o),
        .win_idx_o      (idx_o)
    );

    function automatic logic [SLOT_W-1:0] std_fr(input logic [10:0] b, input logic r);
        return {1'b0, r, b, 18'h0};
    endfunction

    function automatic logic [SLOT_W-1:0] ext_fr(input logic [10:0] b, input logic [17:0] e,
                                                 input logic r);
        return {1'b1, r, b, e};
    endfunction

    task automatic chk(input string req, input logic ev, input logic [4:0] ei);
        n_chk++;
        if (valid_o !== ev || idx_o !== ei) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     req, valid_o, idx_o, ev, ei);
        end
    endtask

    task automatic chk_order(input string req, input logic exp);
        n_chk++;
        if (ord_out !== exp) begin
            n_fail++;
            $display("FAIL %s: got order=%0b, expected order=%0b", req, ord_out, exp);
        end
    endtask

    task automatic clear_all();
        pend = '0;
        for (int i = 0; i < NMB; i++) fr[i] = '1;
    endtask

    task automatic do_eval();
        @(negedge clk) eval = 1'b1;
        @(negedge clk) eval = 1'b0;
    endtask

    task automatic write_order(input logic v, input logic stop);
        @(negedge clk);
        stopped = stop; ord_wr = 1'b1; ord_val = v;
        @(negedge clk);
        ord_wr = 1'b0; stopped = 1'b0;
    endtask

    task automatic t_reset();
        chk_order("R1 order after reset", 1'b0);
        chk("R1 outputs after reset", 1'b0, 5'd0);
    endtask

    task automatic t_order_lock();
        write_order(1'b1, 1'b0);
        chk_order("R2 write while running ignored", 1'b0);
        write_order(1'b1, 1'b1);
        chk_order("R2 write while stopped taken", 1'b1);
        write_order(1'b0, 1'b0);
        chk_order("R2 clear while running ignored", 1'b1);
    endtask

    task automatic t_number_order();
        clear_all();
        fr[3] = std_fr(11'h001, 1'b0);
        pend[3] = 1'b1; pend[17] = 1'b1; pend[9] = 1'b1;
        do_eval();
        chk("R4 highest pending number", 1'b1, 5'd17);
        pend = '0; pend[0] = 1'b1; pend[2] = 1'b1;
        do_eval();
        chk("R3 bit0 ignored in number order", 1'b1, 5'd2);
        pend = 32'h8000_0002;
        do_eval();
        chk("R4 mailbox 31 first", 1'b1, 5'd31);
    endtask

    task automatic t_base_id();
        write_order(1'b0, 1'b1);
        clear_all();
        fr[5]  = std_fr(11'h100, 1'b0);
        fr[9]  = std_fr(11'h050, 1'b0);
        fr[20] = std_fr(11'h200, 1'b0);
        pend[5] = 1'b1; pend[9] = 1'b1; pend[20] = 1'b1;
        do_eval();
        chk("R5 lowest base id", 1'b1, 5'd9);
    endtask

    task automatic t_hold();
        pend = '0; pend[20] = 1'b1;
        fr[20] = std_fr(11'h000, 1'b0);
        repeat (3) @(negedge clk);
        chk("R10 hold without eval", 1'b1, 5'd9);
        do_eval();
        chk("R10 update after eval", 1'b1, 5'd20);
    endtask

    task automatic t_format();
        clear_all();
        fr[4] = std_fr(11'h123, 1'b0);
        fr[7] = ext_fr(11'h123, 18'h0, 1'b0);
        pend[4] = 1'b1; pend[7] = 1'b1;
        do_eval();
        chk("R6 std data beats ext", 1'b1, 5'd4);
        fr[4] = std_fr(11'h123, 1'b1);
        do_eval();
        chk("R6 std remote beats ext", 1'b1, 5'd4);
        fr[12] = ext_fr(11'h122, 18'h3FFFF, 1'b1);
        pend[12] = 1'b1;
        do_eval();
        chk("R6 lower base ext beats std", 1'b1, 5'd12);
        clear_all();
        fr[10] = ext_fr(11'h040, 18'h00010, 1'b0);
        fr[11] = ext_fr(11'h040, 18'h00001, 1'b0);
        fr[30] = ext_fr(11'h040, 18'h00002, 1'b0);
        pend[10] = 1'b1; pend[11] = 1'b1; pend[30] = 1'b1;
        do_eval();
        chk("R6 lowest extension", 1'b1, 5'd11);
    endtask

    task automatic t_remote();
        clear_all();
        fr[3] = std_fr(11'h300, 1'b0);
        fr[8] = std_fr(11'h300, 1'b1);
        pend[3] = 1'b1; pend[8] = 1'b1;
        do_eval();
        chk("R7 data beats remote std", 1'b1, 5'd3);
        fr[3] = ext_fr(11'h300, 18'h5, 1'b1);
        fr[8] = ext_fr(11'h300, 18'h5, 1'b0);
        do_eval();
        chk("R7 data beats remote ext", 1'b1, 5'd8);
    endtask

    task automatic t_tie();
        clear_all();
        fr[6]  = ext_fr(11'h011, 18'h22, 1'b0);
        fr[25] = ext_fr(11'h011, 18'h22, 1'b0);
        pend[6] = 1'b1; pend[25] = 1'b1;
        do_eval();
        chk("R8 tie higher number", 1'b1, 5'd25);
    endtask

    task automatic t_empty();
        clear_all();
        fr[0] = std_fr(11'h000, 1'b0);
        pend[0] = 1'b1;
        do_eval();
        chk("R3 slot 0 never wins", 1'b0, 5'd0);
        pend = '0;
        do_eval();
        chk("R9 nothing pending", 1'b0, 5'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; stopped = 1'b0; ord_wr = 1'b0; ord_val = 1'b0; eval = 1'b0;
        clear_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order_lock();
        t_number_order();
        t_base_id();
        t_hold();
        t_format();
        t_remote();
        t_tie();
        t_empty();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule